// File: doc/BRIEF.md
# Per-bit management status and control cells

This block is a row of single-bit register cells for a management register. The kind of each bit is fixed at elaboration. It can be a plain status mirror, a control bit, a control bit that clears itself, or a status bit that remembers an event until software reads it. Each bit sees a live hardware status input, a shared read strobe, and a shared write strobe with write data. The block returns the value that a read should present, drives the stored control bits out to the hardware, and raises one interrupt request from transition-capturing bits that software has enabled.

A read strobe returns the captured values in the same cycle. The clear or reload that a read causes is registered at the following clock edge. Because the reload samples the live input at that edge, an event that arrives in the same cycle as the read is kept for the next read. The serial or parallel bus that produces the strobes sits outside this block.

Top module: `srb_status_bank`

## Requirements
- R1: A read-only bit (kind code 0) presents its live input on `rdata_o` in the same cycle and ignores writes. It never drives `ctrl_o`.
- R2: A write-only bit (kind code 1) stores `wdata_i` on a write and drives the stored value on `ctrl_o`. It always reads as 0.
- R3: A read/write bit (kind code 2) stores `wdata_i` on a write and presents the stored value on both `rdata_o` and `ctrl_o`.
- R4: A self-clearing bit (kind code 3) is set by writing 1. It then stays 1 on `ctrl_o` and `rdata_o` for exactly `SC_CYCLES` clock cycles after the write edge, and then returns to 0.
- R5: A self-clearing bit clears at the next edge when its `done_i` bit is 1. If a write of 1 arrives in the same cycle as done, the write wins and restarts the bit.
- R6: A latch-low bit (kind code 4) becomes 0 at the edge where its live input is 0. It stays 0 until a read. At the edge of the read it takes the live value.
- R7: A latch-high bit (kind code 5) becomes 1 at the edge where its live input is 1. It stays 1 until a read. At the edge of the read it takes the live value.
- R8: A transition bit (kind code 6) follows its live input until the input changes. It then holds the new value and stays pending, ignoring further changes, until a read. At the edge of the read it reloads the live value.
- R9: A read presents the captured value in the read cycle. An input change or level present at the edge of the read is kept: after the read, the latch-low or latch-high bit shows that level, and a transition bit is pending again.
- R10: `irq_o` is the OR of the pending transition bits whose `irq_en_i` bit is 1. It drops after a read when no new transition coincides with the read. Disabled or non-transition bits never raise it.
- R11: A synchronous reset loads the stored and latched bits from `RST_VAL`, clears every pending flag and forces `irq_o` low. The default layout is bit0 RO, bit1 WO, bit2 RW, bit3 SC, bit4 LL, bit5 LH, bit6 and bit7 LT, with `RST_VAL` = 8'h10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| status_i | input | WIDTH | Live hardware status, one per bit |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | WIDTH | Write data |
| done_i | input | WIDTH | Early completion for self-clearing bits |
| irq_en_i | input | WIDTH | Interrupt enable per transition bit |
| rdata_o | output | WIDTH | Value presented for a read |
| ctrl_o | output | WIDTH | Stored control bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the ones where the live input changes in exactly the cycle of a read strobe, and where a transition bit sees a second change while it is still pending. The vector table changes `status_i` on the same falling edge that raises `rd_i`. It then checks that the reloaded latch-high value and the re-armed transition flag show up in the next read. A further row reverts a transition input before the read, so that the held value differs from the live one. For the self-clearing bit, the bench checks its exact lifetime cycle by cycle, and also checks a done pulse that collides with a new write.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [2:0] {
        BK_RO = 3'd0,
        BK_WO = 3'd1,
        BK_RW = 3'd2,
        BK_SC = 3'd3,
        BK_LL = 3'd4,
        BK_LH = 3'd5,
        BK_LT = 3'd6
    } bit_kind_e;

    localparam int DEF_WIDTH = 8;

    // bit7 .. bit0
    localparam logic [3*DEF_WIDTH-1:0] DEF_KINDS =
        {BK_LT, BK_LT, BK_LH, BK_LL, BK_SC, BK_RW, BK_WO, BK_RO};

    localparam logic [DEF_WIDTH-1:0] DEF_RST = 8'h10;

endpackage

// File: rtl/srb_ctrl_cell.sv
module srb_ctrl_cell #(
    parameter srb_pkg::bit_kind_e KIND      = srb_pkg::BK_RW,
    parameter logic               RST_BIT   = 1'b0,
    parameter int                 SC_CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic done_i,
    output logic q_o
);
    import srb_pkg::*;

    localparam int             CW  = (SC_CYCLES < 2) ? 1 : $clog2(SC_CYCLES + 1);
    localparam logic [CW-1:0]  LIM = CW'(SC_CYCLES - 1);

    typedef struct packed {
        logic          q;
        logic [CW-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.q   = wbit_i;
            s_d.cnt = '0;
        end else if (KIND == BK_SC && s_q.q) begin
            if (done_i || s_q.cnt == LIM) begin
                s_d.q   = 1'b0;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.q   <= RST_BIT;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q_o = s_q.q;

    // R3: a write lands in the stored bit at the next edge
    a_r3_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i |=> (s_q.q == $past(wbit_i)));

    if (KIND == BK_SC) begin : g_sc
        // R5: done pulse ends the operation early
        a_r5_done_ends: assert property (@(posedge clk_i) disable iff (rst_i)
            (s_q.q && done_i && !wr_i) |=> !s_q.q);
        // R4: the lifetime counter stays within the configured window
        a_r4_cnt_in_window: assert property (@(posedge clk_i) disable iff (rst_i)
            s_q.q |-> (s_q.cnt <= LIM));
    end

endmodule

// File: rtl/srb_latch_cell.sv
module srb_latch_cell #(
    parameter srb_pkg::bit_kind_e KIND    = srb_pkg::BK_LL,
    parameter logic               RST_BIT = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic live_i,
    input  logic rd_i,
    output logic val_o,
    output logic pend_o
);
    import srb_pkg::*;

    typedef struct packed {
        logic q;
        logic lat;
        logic prv;
    } latch_st_t;

    latch_st_t s_d, s_q;
    logic      chg;

    always_comb begin
        s_d     = s_q;
        s_d.prv = live_i;
        chg     = live_i ^ s_q.prv;
        if (KIND == BK_LL) begin
            s_d.q = rd_i ? live_i : (s_q.q & live_i);
        end else if (KIND == BK_LH) begin
            s_d.q = rd_i ? live_i : (s_q.q | live_i);
        end else if (rd_i || !s_q.lat) begin
            // reload on read; while unlatched, follow and arm on a change
            s_d.q   = live_i;
            s_d.lat = chg;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.q   <= RST_BIT;
            s_q.lat <= 1'b0;
            s_q.prv <= RST_BIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign val_o  = s_q.q;
    assign pend_o = s_q.lat;

    // R9: the edge of a read reloads the live level seen at that edge
    a_r9_read_reloads: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_i |=> (s_q.q == $past(live_i)));

    if (KIND == BK_LL) begin : g_ll
        a_r6_low_sticks: assert property (@(posedge clk_i) disable iff (rst_i)
            (!rd_i && !s_q.q) |=> !s_q.q);
    end else if (KIND == BK_LH) begin : g_lh
        a_r7_high_sticks: assert property (@(posedge clk_i) disable iff (rst_i)
            (!rd_i && s_q.q) |=> s_q.q);
    end else begin : g_lt
        a_r8_pending_holds: assert property (@(posedge clk_i) disable iff (rst_i)
            (s_q.lat && !rd_i) |=> (s_q.lat && $stable(s_q.q)));
    end

endmodule

// File: rtl/srb_status_bank.sv
module srb_status_bank #(
    parameter int                 WIDTH     = srb_pkg::DEF_WIDTH,
    parameter logic [3*WIDTH-1:0] KINDS     = srb_pkg::DEF_KINDS,
    parameter logic [WIDTH-1:0]   RST_VAL   = srb_pkg::DEF_RST,
    parameter int                 SC_CYCLES = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] status_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] done_i,
    input  logic [WIDTH-1:0] irq_en_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [WIDTH-1:0] ctrl_o,
    output logic             irq_o
);
    import srb_pkg::*;

    logic [WIDTH-1:0] pend;
    logic [WIDTH-1:0] unused_bits;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam bit_kind_e KIND = bit_kind_e'(KINDS[3*i +: 3]);

        if (KIND == BK_WO || KIND == BK_RW || KIND == BK_SC) begin : g_ctrl
            logic q;
            srb_ctrl_cell #(
                .KIND      (KIND),
                .RST_BIT   (RST_VAL[i]),
                .SC_CYCLES (SC_CYCLES)
            ) cell_i (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .wr_i   (wr_i),
                .wbit_i (wdata_i[i]),
                .done_i (done_i[i]),
                .q_o    (q)
            );
            assign rdata_o[i]     = (KIND == BK_WO) ? 1'b0 : q;
            assign ctrl_o[i]      = q;
            assign pend[i]        = 1'b0;
            assign unused_bits[i] = status_i[i];
        end else if (KIND == BK_LL || KIND == BK_LH || KIND == BK_LT) begin : g_latch
            logic v, p;
            srb_latch_cell #(
                .KIND    (KIND),
                .RST_BIT (RST_VAL[i])
            ) cell_i (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .live_i (status_i[i]),
                .rd_i   (rd_i),
                .val_o  (v),
                .pend_o (p)
            );
            assign rdata_o[i]     = v;
            assign ctrl_o[i]      = 1'b0;
            assign pend[i]        = (KIND == BK_LT) ? p : 1'b0;
            assign unused_bits[i] = wdata_i[i] ^ done_i[i];
        end else begin : g_ro
            assign rdata_o[i]     = (KIND == BK_RO) ? status_i[i] : 1'b0;
            assign ctrl_o[i]      = 1'b0;
            assign pend[i]        = 1'b0;
            assign unused_bits[i] = wdata_i[i] ^ done_i[i];
        end
    end

    assign irq_o = |(pend & irq_en_i);

    // R10: a read with no coincident input change leaves nothing pending
    a_r10_read_drops_irq: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !$past(rst_i) && $stable(status_i)) |=> !irq_o);

    // R11: during reset no control bit from a zero reset value is driven
    a_r11_reset_ctrl: assert property (@(posedge clk_i)
        rst_i |=> ((ctrl_o & ~RST_VAL) == '0 || rst_i == 1'b0));

endmodule

// File: tb/srb_status_bank_tb_top.sv
module srb_status_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] status, wdata, done, irq_en;
    logic       rd, wr;
    logic [7:0] rdata, ctrl;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    srb_status_bank dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .status_i (status),
        .rd_i     (rd),
        .wr_i     (wr),
        .wdata_i  (wdata),
        .done_i   (done),
        .irq_en_i (irq_en),
        .rdata_o  (rdata),
        .ctrl_o   (ctrl),
        .irq_o    (irq)
    );

    // fields: status, rd, wr, wdata, exp rdata, exp ctrl, exp irq
    localparam int NV = 13;
    localparam logic [34:0] VECS [0:NV-1] = '{
        {8'h10, 1'b0, 1'b1, 8'h06, 8'h10, 8'h00, 1'b0}, // R3 write WO+RW
        {8'h11, 1'b1, 1'b0, 8'h00, 8'h15, 8'h06, 1'b0}, // R1 live RO, RW readback
        {8'h01, 1'b0, 1'b0, 8'h00, 8'h15, 8'h06, 1'b0}, // R6 LL input drops
        {8'h11, 1'b0, 1'b0, 8'h00, 8'h05, 8'h06, 1'b0}, // R6 LL holds 0
        {8'h31, 1'b1, 1'b0, 8'h00, 8'h05, 8'h06, 1'b0}, // R7 LH event at read
        {8'h11, 1'b0, 1'b0, 8'h00, 8'h35, 8'h06, 1'b0}, // R9 LH event kept
        {8'h51, 1'b0, 1'b0, 8'h00, 8'h35, 8'h06, 1'b0}, // R8 LT6 rises
        {8'h11, 1'b0, 1'b0, 8'h00, 8'h75, 8'h06, 1'b1}, // R10 enabled LT pending
        {8'h91, 1'b1, 1'b0, 8'h00, 8'h75, 8'h06, 1'b1}, // R8 held while live fell
        {8'h91, 1'b0, 1'b0, 8'h00, 8'h95, 8'h06, 1'b0}, // R10 LT7 not enabled
        {8'h11, 1'b1, 1'b0, 8'h00, 8'h95, 8'h06, 1'b0}, // R9 LT7 change at read
        {8'h11, 1'b0, 1'b1, 8'h03, 8'h15, 8'h06, 1'b0}, // R3 clear RW, R1 write ignored
        {8'h10, 1'b0, 1'b0, 8'h00, 8'h10, 8'h02, 1'b0}  // R2 WO reads 0, drives ctrl
    };
    localparam int ROW_REQ [0:NV-1] = '{3, 1, 6, 6, 7, 9, 8, 10, 8, 10, 9, 3, 2};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; status = 8'h10; rd = 1'b0; wr = 1'b0;
        wdata = 8'h00; done = 8'h00; irq_en = 8'h40;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R11 reset rdata", rdata, 8'h10);
        chk("R11 reset ctrl", ctrl, 8'h00);
        chk("R11 reset irq", {7'd0, irq}, 8'h00);

        for (int r = 0; r < NV; r++) begin
            @(negedge clk);
            rst    = 1'b0;
            status = VECS[r][34:27];
            rd     = VECS[r][26];
            wr     = VECS[r][25];
            wdata  = VECS[r][24:17];
            #1;
            chk($sformatf("R%0d row %0d rdata", ROW_REQ[r], r), rdata, VECS[r][16:9]);
            chk($sformatf("R%0d row %0d ctrl", ROW_REQ[r], r), ctrl, VECS[r][8:1]);
            chk($sformatf("R%0d row %0d irq", ROW_REQ[r], r), {7'd0, irq}, {7'd0, VECS[r][0]});
        end

        // R1: read-only bit follows the live input directly
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; status = 8'h11;
        #1;
        chk("R1 live mirror", {7'd0, rdata[0]}, 8'h01);
        @(negedge clk);
        status = 8'h10;

        // R4: self-clearing lifetime
        @(negedge clk);
        wr = 1'b1; wdata = 8'h08;
        @(negedge clk);
        wr = 1'b0;
        for (int k = 0; k < 8; k++) begin
            #1;
            chk($sformatf("R4 sc alive cycle %0d", k), {6'd0, rdata[3], ctrl[3]}, 8'h03);
            @(negedge clk);
        end
        #1;
        chk("R4 sc expired", {6'd0, rdata[3], ctrl[3]}, 8'h00);

        // R5: done ends it early
        @(negedge clk);
        wr = 1'b1; wdata = 8'h08;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        done = 8'h08;
        @(negedge clk);
        done = 8'h00;
        #1;
        chk("R5 done clears", {7'd0, ctrl[3]}, 8'h00);

        // R5: write in the same cycle as done wins
        @(negedge clk);
        wr = 1'b1; wdata = 8'h08; done = 8'h08;
        @(negedge clk);
        wr = 1'b0; done = 8'h00;
        #1;
        chk("R5 write beats done", {7'd0, ctrl[3]}, 8'h01);

        // R11: reset in the middle of activity
        @(negedge clk);
        wr = 1'b1; wdata = 8'h0E;
        @(negedge clk);
        wr = 1'b0;
        #1;
        chk("R3 all ctrl set", ctrl, 8'h0E);
        @(negedge clk);
        rst = 1'b1; status = 8'h10;
        @(negedge clk);
        #1;
        chk("R11 mid reset ctrl", ctrl, 8'h00);
        chk("R11 mid reset rdata", rdata, 8'h10);
        chk("R11 mid reset irq", {7'd0, irq}, 8'h00);

        summary();
        $finish;
    end

endmodule